// File: doc/BRIEF.md
# Masked Input-Change Interrupt Generator

This block watches a bank of general-purpose pins and raises an active-low interrupt request toward a host. The request is raised when a pin changes level, but only for pins that the direction setting marks as inputs and whose mask bit is clear. Rising and falling transitions both count as a change. Every pin is resynchronised into the block clock domain before its edges are compared, so asynchronous pin activity is safe to feed straight in.

The request is sticky: once raised it stays active until the register block sends a one-cycle clear pulse. The register block sends that pulse when the host reads the pin levels. A change seen in the same cycle as the clear wins, so no event is lost. The block keeps a copy of each pin's last level on every cycle, whatever the mask says. This means that unmasking a port, or turning it into an input, does not on its own produce an interrupt for a change that happened earlier.

Top module: `gpio_irq_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `irq_n_o` is 1 (inactive).
- R2: A 0-to-1 transition on a pin whose `dir_i` bit is 1 and whose `mask_i` bit is 0 drives `irq_n_o` to 0. The output changes after the third rising clock edge that follows the pin change, and is still 1 after the second edge. This holds for each of the 16 ports.
- R3: A 1-to-0 transition on such a pin drives `irq_n_o` to 0 with the same latency as R2.
- R4: A transition on a pin whose `mask_i` bit is 1 leaves `irq_n_o` at 1.
- R5: A transition on a pin whose `dir_i` bit is 0 (output) leaves `irq_n_o` at 1.
- R6: Once `irq_n_o` is 0, it stays 0 for as long as `clr_i` is low.
- R7: A one-cycle `clr_i` pulse with no concurrent qualifying change returns `irq_n_o` to 1 after that clock edge.
- R8: If a qualifying change reaches the edge detector in the same cycle that `clr_i` is high, `irq_n_o` is 0 after that edge.
- R9: Clearing a mask bit or setting a direction bit after the pin has already settled does not raise `irq_n_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_i | input | 16 | Asynchronous pin levels |
| dir_i | input | 16 | Per-port direction, 1 = input, 0 = output |
| mask_i | input | 16 | Per-port interrupt mask, 1 = masked |
| clr_i | input | 1 | One-cycle clear from the register block |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
A corrupted synchroniser or previous-level register shows up at `irq_n_o` as one of two faults. The first is a missing or extra interrupt. The second is one that falls a cycle early or late, and the bench catches it by sampling exactly two and three edges after each pin change. A latch that drops its state, or ignores the clear, shows within one cycle of the clear pulse or of the following idle cycles. A stale previous level that is gated only by the mask would surface as a false interrupt within one cycle of unmasking.

// File: rtl/gpio_irq_pkg.sv
// Package: shared defaults and the request-latch state type.
package gpio_irq_pkg;
    parameter int unsigned GPIO_W_DEF   = 16;
    parameter int unsigned SYNC_DEF     = 2;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;
endpackage

// File: rtl/gpio_irq_sync.sv
// Multi-stage synchroniser for a bank of asynchronous pins.
// Assumes each pin toggles slower than the block clock; no bus coherency
// across pins is claimed. Resets all stages to 0.
module gpio_irq_sync #(
    parameter int unsigned W      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // capture raw pin levels
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= async_i;
            end
        end else begin : g_next
            // shift through the metastability chain
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_edge.sv
// Both-edge change detector with direction and mask qualification.
// The previous-level copy updates every cycle regardless of qualification,
// so enabling a port later never reports a stale change.
module gpio_irq_edge #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] evt_o
);
    logic [W-1:0] prev_q;

    // remember last synchronised level, unconditionally
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    for (genvar i = 0; i < W; i++) begin : g_port
        // per-port change, allowed only on unmasked inputs
        always_comb begin
            evt_o[i] = (lvl_i[i] ^ prev_q[i]) & dir_i[i] & ~mask_i[i];
        end
    end
endmodule

// File: rtl/gpio_irq_latch.sv
// Sticky interrupt request. Set has priority over clear so that a change
// arriving with the clear pulse is kept. Output is active low.
module gpio_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n_o
);
    import gpio_irq_pkg::*;

    irq_state_e state_q, state_d;

    // next state: set wins over clear
    always_comb begin
        state_d = state_q;
        if (set_i)      state_d = IRQ_PEND;
        else if (clr_i) state_d = IRQ_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    assign irq_n_o = (state_q != IRQ_PEND);
endmodule

// File: rtl/gpio_irq_gen.sv
// Top: synchroniser -> qualified change detector -> sticky latch.
// Assumes clr_i is a single-cycle pulse from the register block.
module gpio_irq_gen #(
    parameter int unsigned W      = gpio_irq_pkg::GPIO_W_DEF,
    parameter int unsigned STAGES = gpio_irq_pkg::SYNC_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] mask_i,
    input  logic         clr_i,
    output logic         irq_n_o
);
    logic [W-1:0] lvl_w;
    logic [W-1:0] evt_w;
    logic         any_evt_w;

    gpio_irq_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (lvl_w)
    );

    gpio_irq_edge #(.W(W)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl_w),
        .dir_i  (dir_i),
        .mask_i (mask_i),
        .evt_o  (evt_w)
    );

    assign any_evt_w = |evt_w;

    gpio_irq_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (any_evt_w),
        .clr_i   (clr_i),
        .irq_n_o (irq_n_o)
    );
endmodule

// File: rtl/gpio_irq_gen_chk.sv
// Checker for gpio_irq_gen, bound to every instance.
module gpio_irq_gen_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr_i,
    input logic         irq_n_o,
    input logic [W-1:0] evt
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> irq_n_o);

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n_o && !clr_i) |=> !irq_n_o);

    // R7
    clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (evt == '0)) |=> irq_n_o);

    // R8
    event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> !irq_n_o);

    // R2
    fall_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n_o) |-> $past(evt != '0));
endmodule

bind gpio_irq_gen gpio_irq_gen_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr_i),
    .irq_n_o (irq_n_o),
    .evt     (evt_w)
);

// File: tb/gpio_irq_gen_tb.sv
module gpio_irq_gen_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] pin, dir, mask;
    logic         clr;
    logic         irq_n;
    int           checks = 0;
    int           errors = 0;
    bit           done   = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_gen u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .dir_i(dir),
        .mask_i(mask), .clr_i(clr), .irq_n_o(irq_n)
    );

    task automatic advance(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: irq_n=%b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        advance(1);
        clr = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; pin = '0; dir = '1; mask = '1; clr = 1'b0;
        advance(3);
        chk(irq_n, 1'b1, "R1 during reset");
        rst_n = 1'b1;
        advance(1);
        chk(irq_n, 1'b1, "R1 after reset");

        // sweep every port over all direction/mask combinations, both edges
        for (int i = 0; i < W; i++) begin
            for (int c = 0; c < 4; c++) begin
                dir  = '1; mask = '0;
                dir[i]  = c[0];
                mask[i] = c[1];
                for (int e = 0; e < 2; e++) begin
                    logic  en;
                    string tag;
                    en  = c[0] && !c[1];
                    tag = !c[0] ? "R5" : c[1] ? "R4" : (pin[i] ? "R3" : "R2");
                    pin[i] = ~pin[i];
                    advance(2);
                    chk(irq_n, 1'b1, {tag, " before latency"});
                    advance(1);
                    chk(irq_n, !en, {tag, " after latency"});
                    advance(2);
                    chk(irq_n, !en, "R6 held");
                    pulse_clr();
                    chk(irq_n, 1'b1, "R7 cleared");
                end
            end
        end

        // several ports at once, some masked
        dir = '1; mask = 16'h00F0;
        pin = pin ^ 16'h0F30;
        advance(3);
        chk(irq_n, 1'b0, "R2 multi-port");
        advance(1);
        pulse_clr();
        chk(irq_n, 1'b1, "R7 multi-port clear");

        // clear colliding with a fresh change: latch already set
        mask = '0;
        pin[3] = ~pin[3];
        advance(4);
        chk(irq_n, 1'b0, "R6 pre-collision");
        pin[7] = ~pin[7];
        advance(2);
        clr = 1'b1;
        advance(1);
        clr = 1'b0;
        chk(irq_n, 1'b0, "R8 change wins over clear");
        pulse_clr();
        chk(irq_n, 1'b1, "R7 after collision");

        // unmask after a masked change has settled
        mask = 16'h0020;
        pin[5] = ~pin[5];
        advance(4);
        chk(irq_n, 1'b1, "R4 masked toggle");
        mask = '0;
        advance(4);
        chk(irq_n, 1'b1, "R9 unmask no spurious");

        // make a port an input after it changed as an output
        dir = 16'hFFF7;
        pin[3] = ~pin[3];
        advance(4);
        chk(irq_n, 1'b1, "R5 output toggle");
        dir = '1;
        advance(4);
        chk(irq_n, 1'b1, "R9 direction change no spurious");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule